// File: doc/BRIEF.md
# Three-Segment Memory Protection Classifier

This block places every address seen on a 20-bit memory address bus into one of three main-memory segments, or into none of them. Two 16-bit border registers set where the segments meet. Each border value lines up with address bits [19:4]. This gives a compare on the 16 upper address bits against the borders, and a segment granularity of 1 KB. A one-cycle write port loads the borders. The port clears the border bits that the memory-size parameter fixes, so those bits always read back as zero.

The smaller of the two borders ends the lowest segment. The larger border ends the middle segment. The block therefore gives the same result whichever register holds the larger value. Equal borders remove the middle segment. Every segment has its own read, write and execute enables. A combinational violation flag rises when the access type presented with the address is not enabled in the segment it falls into. Addresses outside the main-memory window, set by the parameters `MEM_LO` and `MEM_HI`, fall into no segment and never raise a violation.

Top module: `mpu_seg_classifier`

## Requirements
- R1: After reset both border registers read zero, and every main-memory address is classified as segment 3.
- R2: A border write stores the written value with the fixed bits cleared. With `SIZE_CLASS`=0, only bits [13:6] keep their value. With `SIZE_CLASS`=1, bits [14:6] keep their value. Bits [5:0] are always cleared.
- R3: A write with `brd_sel`=0 changes only border A, and a write with `brd_sel`=1 changes only border B. With `brd_we` low, both borders hold their value.
- R4: A main-memory address whose bits [19:4] are below the smaller border is reported as segment 1 (`seg_id`=1).
- R5: A main-memory address whose bits [19:4] are at or above the smaller border and below the larger border is reported as segment 2 (`seg_id`=2).
- R6: A main-memory address whose bits [19:4] are at or above the larger border is reported as segment 3 (`seg_id`=3).
- R7: Swapping the values held in border A and border B does not change the classification of any address.
- R8: When both borders are equal, `seg_id` is never 2.
- R9: An address below `MEM_LO` or above `MEM_HI` gives `seg_id`=0 and `violation`=0.
- R10: Access codes are 0=read, 1=write, 2=execute and 3=no access. For segment s (1..3), the enable for access code k is `perm[3*(s-1)+k]`. `violation` is high exactly when the address is in a segment, the code is 0 to 2, and that enable bit is 0.
- R11: A border write shows at `brd_a_q`/`brd_b_q` and in the classification only after the clock edge that samples it. Classification and `violation` follow `addr`, `acc_type` and `perm` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brd_we | input | 1 | Border write strobe |
| brd_sel | input | 1 | Border to write: 0 = A, 1 = B |
| brd_wdata | input | 16 | Border write value |
| brd_a_q | output | 16 | Border A readback |
| brd_b_q | output | 16 | Border B readback |
| addr | input | 20 | Address bus value to classify |
| acc_type | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 none |
| perm | input | 9 | Per-segment enables, three bits per segment |
| seg_id | output | 2 | 0 none, 1/2/3 segment number |
| violation | output | 1 | Access not enabled in the matched segment |

## Verification
Only the two border registers hold state, so a wrong stored border shows up straight away at `brd_a_q`/`brd_b_q`, on the cycle after the write. A wrong fixed-bit mask, a lost write, or a write that lands in the other register can be seen there without any address traffic. A fault in the min/max ordering or in a compare shows up as a wrong `seg_id` only for addresses near a border. For that reason the bench sweeps every 16-byte page of the window for each border pair, with the pair also loaded in swapped order. A wrong permission index shows up as a wrong `violation` in the same cycle as the address, which is why the sweep checks all four access codes at every address.

// File: rtl/mpuseg_pkg.sv
package mpuseg_pkg;
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,
      SEG_LOW  = 2'd1,
      SEG_MID  = 2'd2,
      SEG_HIGH = 2'd3
   } seg_e;

   typedef enum logic [1:0] {
      ACC_RD   = 2'd0,
      ACC_WR   = 2'd1,
      ACC_EX   = 2'd2,
      ACC_IDLE = 2'd3
   } acc_e;

   localparam int NUM_SEG  = 3;
   localparam int NUM_PERM = 3;
endpackage

// File: rtl/mpuseg_borders.sv
module mpuseg_borders #(
   parameter int BRD_W      = 16,
   parameter int GRAN_BITS  = 6,
   parameter int SIZE_CLASS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sel,
   input  logic [BRD_W-1:0] wdata,
   output logic [BRD_W-1:0] a_q,
   output logic [BRD_W-1:0] b_q,
   output logic [BRD_W-1:0] lo_q,
   output logic [BRD_W-1:0] hi_q
);
   // Number of top border bits that the memory size forces to zero.
   localparam int TOP_FIX = (SIZE_CLASS == 0) ? 2 : 1;
   localparam logic [31:0] KEEP_HI = (32'd1 << (BRD_W - TOP_FIX)) - 32'd1;
   localparam logic [31:0] KEEP_LO = (32'd1 << GRAN_BITS) - 32'd1;
   localparam logic [BRD_W-1:0] MASK = BRD_W'(KEEP_HI & ~KEEP_LO);

   generate
      if (SIZE_CLASS != 0 && SIZE_CLASS != 1) begin : g_bad_class
         $error("mpuseg_borders: SIZE_CLASS must be 0 or 1");
      end
      if (GRAN_BITS >= BRD_W - TOP_FIX) begin : g_bad_gran
         $error("mpuseg_borders: GRAN_BITS leaves no writable bits");
      end
   endgenerate

   logic [1:0][BRD_W-1:0] regs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (we) begin
         for (int i = 0; i < 2; i++) begin
            if (sel == 1'(i)) regs_q[i] <= wdata & MASK;
         end
      end
   end

   assign a_q  = regs_q[0];
   assign b_q  = regs_q[1];
   assign lo_q = (regs_q[0] < regs_q[1]) ? regs_q[0] : regs_q[1];
   assign hi_q = (regs_q[0] < regs_q[1]) ? regs_q[1] : regs_q[0];

   assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sel) |=> (a_q == ($past(wdata) & MASK)));
   assert_other_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sel) |=> $stable(b_q));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(a_q) && $stable(b_q)));
   assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q <= hi_q));
endmodule

// File: rtl/mpuseg_compare.sv
module mpuseg_compare
   import mpuseg_pkg::*;
#(
   parameter int              ADDR_W = 20,
   parameter int              BRD_W  = 16,
   parameter logic [ADDR_W-1:0] MEM_LO = 20'h04400,
   parameter logic [ADDR_W-1:0] MEM_HI = 20'h13FFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BRD_W-1:0]  lo,
   input  logic [BRD_W-1:0]  hi,
   output seg_e              seg
);
   localparam int SHIFT = ADDR_W - BRD_W;

   generate
      if (SHIFT < 0) begin : g_bad_w
         $error("mpuseg_compare: BRD_W wider than ADDR_W");
      end
      if (MEM_LO > MEM_HI) begin : g_bad_win
         $error("mpuseg_compare: MEM_LO above MEM_HI");
      end
   endgenerate

   logic [BRD_W-1:0] page;
   logic             in_win;

   assign page   = addr[ADDR_W-1:SHIFT];
   assign in_win = (addr >= MEM_LO) && (addr <= MEM_HI);

   always_comb begin
      if (!in_win)         seg = SEG_NONE;
      else if (page < lo)  seg = SEG_LOW;
      else if (page < hi)  seg = SEG_MID;
      else                 seg = SEG_HIGH;
   end
endmodule

// File: rtl/mpuseg_perm.sv
module mpuseg_perm
   import mpuseg_pkg::*;
(
   input  seg_e                        seg,
   input  acc_e                        acc,
   input  logic [NUM_SEG*NUM_PERM-1:0] perm,
   output logic                        viol
);
   logic [NUM_SEG-1:0] allowed;

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         logic [NUM_PERM-1:0] en;
         assign en = perm[s*NUM_PERM +: NUM_PERM];
         always_comb begin
            case (acc)
               ACC_RD:  allowed[s] = en[0];
               ACC_WR:  allowed[s] = en[1];
               ACC_EX:  allowed[s] = en[2];
               default: allowed[s] = 1'b1;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (seg)
         SEG_LOW:  viol = !allowed[0];
         SEG_MID:  viol = !allowed[1];
         SEG_HIGH: viol = !allowed[2];
         default:  viol = 1'b0;
      endcase
   end
endmodule

// File: rtl/mpu_seg_classifier.sv
module mpu_seg_classifier
   import mpuseg_pkg::*;
#(
   parameter int                ADDR_W     = 20,
   parameter int                BRD_W      = 16,
   parameter int                GRAN_BITS  = 6,
   parameter int                SIZE_CLASS = 0,
   parameter logic [ADDR_W-1:0] MEM_LO     = 20'h04400,
   parameter logic [ADDR_W-1:0] MEM_HI     = 20'h13FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brd_we,
   input  logic              brd_sel,
   input  logic [BRD_W-1:0]  brd_wdata,
   output logic [BRD_W-1:0]  brd_a_q,
   output logic [BRD_W-1:0]  brd_b_q,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        acc_type,
   input  logic [8:0]        perm,
   output logic [1:0]        seg_id,
   output logic              violation
);
   logic [BRD_W-1:0] lo_b, hi_b;
   seg_e             seg;

   mpuseg_borders #(
      .BRD_W(BRD_W), .GRAN_BITS(GRAN_BITS), .SIZE_CLASS(SIZE_CLASS)
   ) u_brd (
      .clk(clk), .rst_n(rst_n), .we(brd_we), .sel(brd_sel), .wdata(brd_wdata),
      .a_q(brd_a_q), .b_q(brd_b_q), .lo_q(lo_b), .hi_q(hi_b)
   );

   mpuseg_compare #(
      .ADDR_W(ADDR_W), .BRD_W(BRD_W), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)
   ) u_cmp (
      .addr(addr), .lo(lo_b), .hi(hi_b), .seg(seg)
   );

   mpuseg_perm u_perm (
      .seg(seg), .acc(acc_e'(acc_type)), .perm(perm), .viol(violation)
   );

   assign seg_id = seg;

   assert_no_mid_when_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (brd_a_q == brd_b_q) |-> (seg_id != 2'd2));
   assert_quiet_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
      violation |-> (seg_id != 2'd0));
   assert_idle_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 2'd3) |-> !violation);
   assert_mid_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_id == 2'd2) |-> (brd_a_q != brd_b_q));
endmodule

// File: tb/sim_mpu_seg_classifier.sv
`timescale 1ns/1ps
module sim_mpu_seg_classifier;
   localparam logic [19:0] LO_A = 20'h04400;
   localparam logic [19:0] HI_A = 20'h13FFF;
   localparam logic [15:0] WMASK = 16'h3FC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        brd_we = 1'b0;
   logic        brd_sel = 1'b0;
   logic [15:0] brd_wdata = '0;
   logic [15:0] brd_a_q, brd_b_q;
   logic [19:0] addr = '0;
   logic [1:0]  acc_type = 2'd3;
   logic [8:0]  perm = '0;
   logic [1:0]  seg_id;
   logic        violation;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mpu_seg_classifier u0 (
      .clk(clk), .rst_n(rst_n), .brd_we(brd_we), .brd_sel(brd_sel),
      .brd_wdata(brd_wdata), .brd_a_q(brd_a_q), .brd_b_q(brd_b_q),
      .addr(addr), .acc_type(acc_type), .perm(perm),
      .seg_id(seg_id), .violation(violation)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 200000) begin
         fails++;
         $display("FAIL watchdog: act=%0d cycles exp<200000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input int act, input int exp, input string tag);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h addr=%0h acc=%0d", tag, act, exp, addr, acc_type);
      end
   endtask

   task automatic wr(input bit sel, input logic [15:0] v);
      logic [15:0] olda, oldb;
      @(negedge clk);
      olda = brd_a_q; oldb = brd_b_q;
      brd_we = 1'b1; brd_sel = sel; brd_wdata = v;
      #1;
      chk(sel ? brd_b_q : brd_a_q, sel ? oldb : olda, "R11 before edge");
      @(posedge clk); #1;
      brd_we = 1'b0;
      chk(sel ? brd_b_q : brd_a_q, v & WMASK, "R2 masked write");
      chk(sel ? brd_a_q : brd_b_q, sel ? olda : oldb, "R3 other kept");
   endtask

   function automatic int exp_seg(logic [19:0] ad, logic [15:0] ra, logic [15:0] rb);
      logic [15:0] mn, mx;
      mn = (ra < rb) ? ra : rb;
      mx = (ra < rb) ? rb : ra;
      if (ad < LO_A || ad > HI_A) return 0;
      if (ad[19:4] < mn) return 1;
      if (ad[19:4] < mx) return 2;
      return 3;
   endfunction

   task automatic sweep(input logic [15:0] ra, input logic [15:0] rb);
      for (int i = 0; i < 16'h1500; i++) begin
         int es;
         addr = {i[15:0], i[3:0]};
         perm = 9'(i * 37 + 5);
         es = exp_seg(addr, ra, rb);
         for (int k = 0; k < 4; k++) begin
            bit ev;
            acc_type = 2'(k);
            #1;
            ev = (es != 0) && (k != 3) && !perm[3*(es-1)+k];
            if (es == 0)      chk(seg_id, es, "R9 outside window");
            else if (es == 1) chk(seg_id, es, "R4 low segment");
            else if (es == 2) chk(seg_id, es, "R5 middle segment");
            else              chk(seg_id, es, "R6 high segment");
            if (es == 0) chk(violation, 0, "R9 no violation outside");
            else         chk(violation, ev, "R10 permission");
            if (ra == rb && seg_id == 2'd2) chk(seg_id, 3, "R8 equal borders");
         end
      end
   endtask

   task automatic pair(input logic [15:0] va, input logic [15:0] vb);
      wr(1'b0, va);
      wr(1'b1, vb);
      sweep(va & WMASK, vb & WMASK);
      // R7: same pair loaded swapped must classify identically.
      wr(1'b0, vb);
      wr(1'b1, va);
      sweep(vb & WMASK, va & WMASK);
   endtask

   initial begin
      #35;
      chk(brd_a_q, 0, "R1 reset border A");
      chk(brd_b_q, 0, "R1 reset border B");
      addr = 20'h05000; acc_type = 2'd3; #1;
      chk(seg_id, 3, "R1 reset classifies high");
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R3: idle cycles keep borders.
      @(posedge clk); #1;
      chk(brd_a_q, 0, "R3 idle hold A");
      wr(1'b0, 16'hFFFF);
      chk(brd_a_q, 16'h3FC0, "R2 all ones masked");
      // R11: classification switches right after the write edge.
      addr = 20'h10000; #1;
      chk(seg_id, 2, "R11 classification after write");
      pair(16'h0800, 16'h1000);
      pair(16'h0C3F, 16'h0C00);
      pair(16'h0000, 16'h0000);
      pair(16'hC440, 16'h1300);
      pair(16'h0500, 16'h3FC0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule